// File: doc/BRIEF.md
# Speculative Load Tracking Table

This block remembers which destination registers currently hold data fetched by a speculative (early) load, together with the physical byte range that was read. A later check names a register and asks whether that speculative data can still be trusted. The answer is "hit" only if no store, semaphore, page purge or cache-line eviction has touched the recorded memory since the load was recorded, and no explicit command has dropped the entry. On a miss, the core re-executes the load. Every removal errs on the safe side: store events match at cache-line granularity, so a store removes any entry that shares a line with it, even when the bytes themselves do not overlap.

Each entry holds a register tag, a physical address, a size code and a valid flag. New speculative loads arrive on an insert port. Checks arrive on a lookup port and can optionally clear the entry they name. Two explicit commands are provided: one drops everything, and one drops a single register's entry. Memory events arrive on one snoop port, each with a kind, an address and a size. All removals that arrive in a cycle act on the state seen by a check in that same cycle. The check answer is registered and appears one cycle after the request.

Top module: `spec_load_table`

## Requirements
- R1: After synchronous reset the table holds no entries: `chk_resp_valid` is 0, and every check reports a miss until something is inserted.
- R2: A check with `chk_valid` set produces `chk_resp_valid` = 1 on the next cycle and no other time. `chk_hit` is 1 in that cycle exactly when a valid entry carries `chk_tag`.
- R3: An insert removes any existing entry with the same tag and records the new tag, address and size, so each tag has at most one entry. Size code c in `ins_size`/`snp_size` means 2^c bytes (0=1, 1=2, 2=4, 3=8).
- R4: A check with `chk_clear` = 1 removes the entry for `chk_tag` after the lookup, whether the check hit or missed. A check with `chk_clear` = 0 changes nothing.
- R5: `inv_all` removes every entry. `inv_one_valid` removes only the entry whose tag equals `inv_one_tag`.
- R6: A snoop of kind store (0) or semaphore (1) removes every entry whose range of 64-byte lines overlaps the range of lines covered by the event's bytes. This includes entries or events that straddle a line boundary, and several entries may be removed at once.
- R7: A snoop of kind page purge (2) removes every entry whose start address lies in the same aligned 4096-byte page as `snp_addr`.
- R8: A snoop of kind line eviction (3) removes every entry whose byte range touches the 64-byte line that contains `snp_addr`. `snp_size` is ignored for this kind.
- R9: A snoop of kind spill store (4), or of an unused kind (5 to 7), removes nothing.
- R10: Within one cycle, a check sees the table after that cycle's `inv_all`, `inv_one`, and snoop removals, but before that cycle's insert. The insert is applied after all removals, so it survives a snoop or command in the same cycle.
- R11: An insert uses the lowest-numbered free slot. When no slot is free, it overwrites the slot at a round-robin pointer. The pointer starts at 0 and advances by one, wrapping, after each such overwrite.
- R12: With `NUM_ENTRIES` = 0, every check reports a miss, and `chk_resp_valid` still follows R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Record a speculative load this cycle |
| ins_tag | input | TAG_W | Destination register of the load |
| ins_addr | input | ADDR_W | Physical start address of the load |
| ins_size | input | 2 | Load size code (2^c bytes) |
| chk_valid | input | 1 | Look up a register this cycle |
| chk_tag | input | TAG_W | Register to look up |
| chk_clear | input | 1 | Remove the looked-up entry afterwards |
| inv_all | input | 1 | Remove all entries |
| inv_one_valid | input | 1 | Remove one register's entry |
| inv_one_tag | input | TAG_W | Register whose entry is removed |
| snp_valid | input | 1 | Memory event present this cycle |
| snp_kind | input | 3 | 0 store, 1 semaphore, 2 page purge, 3 line eviction, 4 spill store |
| snp_addr | input | ADDR_W | Event address |
| snp_size | input | 2 | Event size code (2^c bytes) |
| chk_resp_valid | output | 1 | Registered: a check answer is present |
| chk_hit | output | 1 | Registered: the checked entry was still valid |

## Verification
The bench targets several corner cases that a plausible but wrong design would get wrong:
- A store that shares a cache line with an entry but not its bytes. If the store were matched byte-exact, the entry would survive.
- Entries and stores that cross a line boundary. Taking only the start line would leave stale entries alive.
- A purge that reaches the last word of a page but not the first word of the next page.
- A spill store aimed straight at a recorded address, which must leave the entry in place.
- Same-cycle collisions: a removal racing a check, which must yield a miss, and an insert racing a snoop, which must keep the new entry.
- Filling the table past capacity, to show which victim the round-robin pointer chooses.
- A zero-entry instance that must never hit.

// File: rtl/slt_pkg.sv
package slt_pkg;

  typedef enum logic [2:0] {
    SNP_STORE = 3'd0,
    SNP_SEMA  = 3'd1,
    SNP_PURGE = 3'd2,
    SNP_EVICT = 3'd3,
    SNP_SPILL = 3'd4
  } snp_kind_e;

  // size code c encodes 2^c bytes
  function automatic logic [3:0] size_bytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction

endpackage

// File: rtl/slt_overlap.sv
module slt_overlap #(
  parameter int ADDR_W   = 64,
  parameter int LINE_LSB = 6,
  parameter int PAGE_LSB = 12
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic [1:0]        e_size,
  input  logic              snp_valid,
  input  logic [2:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_size,
  output logic              kill
);
  import slt_pkg::*;

  localparam int LW = ADDR_W - LINE_LSB;

  logic [ADDR_W-1:0] e_last, s_last;
  logic [LW-1:0]     e_lo, e_hi, s_lo, s_hi;
  logic              range_hit, line_hit, page_hit, match;

  always_comb begin
    e_last   = e_addr + ADDR_W'(size_bytes(e_size)) - ADDR_W'(1);
    s_last   = snp_addr + ADDR_W'(size_bytes(snp_size)) - ADDR_W'(1);
    e_lo     = e_addr[ADDR_W-1:LINE_LSB];
    e_hi     = e_last[ADDR_W-1:LINE_LSB];
    s_lo     = snp_addr[ADDR_W-1:LINE_LSB];
    s_hi     = s_last[ADDR_W-1:LINE_LSB];
    range_hit = (e_lo <= s_hi) && (s_lo <= e_hi);
    line_hit  = (e_lo <= s_lo) && (s_lo <= e_hi);
    page_hit  = (e_addr[ADDR_W-1:PAGE_LSB] == snp_addr[ADDR_W-1:PAGE_LSB]);
    case (snp_kind_e'(snp_kind))
      SNP_STORE, SNP_SEMA: match = range_hit;
      SNP_EVICT:           match = line_hit;
      SNP_PURGE:           match = page_hit;
      default:             match = 1'b0;
    endcase
    kill = en & snp_valid & match;
  end

endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   alloc,
  input  logic [NUM_ENTRIES-1:0] free_vec,
  output logic [NUM_ENTRIES-1:0] sel
);
  logic [IDX_W-1:0]       rr_q;
  logic [NUM_ENTRIES-1:0] pick;
  logic                   found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (!found && free_vec[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    if (!found) pick[rr_q] = 1'b1;
    sel = alloc ? pick : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q <= '0;
    end else if (alloc && !found) begin
      rr_q <= (rr_q == IDX_W'(NUM_ENTRIES - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/spec_load_table.sv
module spec_load_table #(
  parameter int NUM_ENTRIES = 16,
  parameter int TAG_W       = 7,
  parameter int ADDR_W      = 64,
  parameter int LINE_BYTES  = 64,
  parameter int PAGE_BYTES  = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [1:0]        ins_size,
  input  logic              chk_valid,
  input  logic [TAG_W-1:0]  chk_tag,
  input  logic              chk_clear,
  input  logic              inv_all,
  input  logic              inv_one_valid,
  input  logic [TAG_W-1:0]  inv_one_tag,
  input  logic              snp_valid,
  input  logic [2:0]        snp_kind,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_size,
  output logic              chk_resp_valid,
  output logic              chk_hit
);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES);

  logic hit_d;

  generate
    if (NUM_ENTRIES == 0) begin : g_empty
      assign hit_d = 1'b0;
    end else begin : g_table
      logic [NUM_ENTRIES-1:0] valid_q;
      logic [TAG_W-1:0]       tag_q  [NUM_ENTRIES];
      logic [ADDR_W-1:0]      addr_q [NUM_ENTRIES];
      logic [1:0]             size_q [NUM_ENTRIES];

      logic [NUM_ENTRIES-1:0] snp_kill, live, tag_chk, kept, sel;

      for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        slt_overlap #(
          .ADDR_W  (ADDR_W),
          .LINE_LSB(LINE_LSB),
          .PAGE_LSB(PAGE_LSB)
        ) u_ovl (
          .en       (valid_q[i]),
          .e_addr   (addr_q[i]),
          .e_size   (size_q[i]),
          .snp_valid(snp_valid),
          .snp_kind (snp_kind),
          .snp_addr (snp_addr),
          .snp_size (snp_size),
          .kill     (snp_kill[i])
        );

        always_comb begin
          live[i]    = valid_q[i] & ~inv_all & ~snp_kill[i]
                     & ~(inv_one_valid & (tag_q[i] == inv_one_tag));
          tag_chk[i] = live[i] & (tag_q[i] == chk_tag);
          kept[i]    = live[i]
                     & ~(chk_valid & chk_clear & (tag_q[i] == chk_tag))
                     & ~(ins_valid & (tag_q[i] == ins_tag));
        end

        always_ff @(posedge clk) begin
          if (rst) valid_q[i] <= 1'b0;
          else     valid_q[i] <= kept[i] | sel[i];
        end

        always_ff @(posedge clk) begin
          if (sel[i]) begin
            tag_q[i]  <= ins_tag;
            addr_q[i] <= ins_addr;
            size_q[i] <= ins_size;
          end
        end
      end

      slt_victim #(.NUM_ENTRIES(NUM_ENTRIES)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .alloc   (ins_valid),
        .free_vec(~kept),
        .sel     (sel)
      );

      assign hit_d = chk_valid & (|tag_chk);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_resp_valid <= 1'b0;
      chk_hit        <= 1'b0;
    end else begin
      chk_resp_valid <= chk_valid;
      chk_hit        <= hit_d;
    end
  end

endmodule

// File: rtl/slt_chk.sv
module slt_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int TAG_W       = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic             chk_valid,
  input logic [TAG_W-1:0] chk_tag,
  input logic             chk_clear,
  input logic             inv_all,
  input logic             inv_one_valid,
  input logic [TAG_W-1:0] inv_one_tag,
  input logic             chk_resp_valid,
  input logic             chk_hit
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !chk_resp_valid);

  // R2
  resp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    chk_valid |=> chk_resp_valid);

  // R2
  resp_only_after_chk: assert property (@(posedge clk) disable iff (rst)
    !chk_valid |=> !chk_resp_valid);

  // R2
  hit_needs_resp_chk: assert property (@(posedge clk) disable iff (rst)
    chk_hit |-> chk_resp_valid);

  // R4
  clear_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && chk_clear && !ins_valid) ##1 (chk_valid && chk_tag == $past(chk_tag))
    |=> !chk_hit);

  // R5
  flush_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !ins_valid) ##1 chk_valid |=> !chk_hit);

  // R10
  same_cycle_flush_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && inv_all) |=> !chk_hit);

  // R10
  same_cycle_drop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && inv_one_valid && inv_one_tag == chk_tag) |=> !chk_hit);

  generate
    if (NUM_ENTRIES == 0) begin : g_zero
      // R12
      zero_never_hit_chk: assert property (@(posedge clk) disable iff (rst)
        !chk_hit);
    end
  endgenerate

endmodule

bind spec_load_table slt_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .TAG_W      (TAG_W)
) u_slt_chk (
  .clk           (clk),
  .rst           (rst),
  .ins_valid     (ins_valid),
  .chk_valid     (chk_valid),
  .chk_tag       (chk_tag),
  .chk_clear     (chk_clear),
  .inv_all       (inv_all),
  .inv_one_valid (inv_one_valid),
  .inv_one_tag   (inv_one_tag),
  .chk_resp_valid(chk_resp_valid),
  .chk_hit       (chk_hit)
);

// File: tb/spec_load_table_bench.sv
module spec_load_table_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        ins_valid, chk_valid, chk_clear, inv_all, inv_one_valid, snp_valid;
  logic [6:0]  ins_tag, chk_tag, inv_one_tag;
  logic [63:0] ins_addr, snp_addr;
  logic [1:0]  ins_size, snp_size;
  logic [2:0]  snp_kind;
  logic        chk_resp_valid, chk_hit, z_resp_valid, z_hit;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  bit          m_v   [N];
  int          m_tag [N];
  longint unsigned m_addr [N];
  int          m_sz  [N];
  int          m_rr;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_load_table u_spec_load_table (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr), .ins_size(ins_size),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
    .inv_all(inv_all), .inv_one_valid(inv_one_valid), .inv_one_tag(inv_one_tag),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_size(snp_size),
    .chk_resp_valid(chk_resp_valid), .chk_hit(chk_hit)
  );

  spec_load_table #(.NUM_ENTRIES(0)) u_zero (
    .clk(clk), .rst(rst),
    .ins_valid(ins_valid), .ins_tag(ins_tag), .ins_addr(ins_addr), .ins_size(ins_size),
    .chk_valid(chk_valid), .chk_tag(chk_tag), .chk_clear(chk_clear),
    .inv_all(inv_all), .inv_one_valid(inv_one_valid), .inv_one_tag(inv_one_tag),
    .snp_valid(snp_valid), .snp_kind(snp_kind), .snp_addr(snp_addr), .snp_size(snp_size),
    .chk_resp_valid(z_resp_valid), .chk_hit(z_hit)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit snoop_hits(input int i);
    longint unsigned e_lo, e_hi, s_lo, s_hi;
    e_lo = m_addr[i] / 64;
    e_hi = (m_addr[i] + (64'd1 << m_sz[i]) - 1) / 64;
    s_lo = snp_addr / 64;
    s_hi = (snp_addr + (64'd1 << snp_size) - 1) / 64;
    case (snp_kind)
      3'd0, 3'd1: return (e_lo <= s_hi) && (s_lo <= e_hi);
      3'd3:       return (e_lo <= s_lo) && (s_lo <= e_hi);
      3'd2:       return (m_addr[i] / 4096) == (snp_addr / 4096);
      default:    return 1'b0;
    endcase
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endfunction

  // Applies this cycle's inputs to the model; returns the expected hit.
  function automatic bit model_step();
    bit hit = 0;
    int slot = -1;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && (inv_all || (inv_one_valid && m_tag[i] == inv_one_tag) ||
                     (snp_valid && snoop_hits(i))))
        m_v[i] = 0;
    end
    for (int i = 0; i < N; i++)
      if (chk_valid && m_v[i] && m_tag[i] == chk_tag) hit = 1;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && chk_valid && chk_clear && m_tag[i] == chk_tag) m_v[i] = 0;
      if (m_v[i] && ins_valid && m_tag[i] == ins_tag) m_v[i] = 0;
    end
    if (ins_valid) begin
      for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
      if (slot < 0) begin
        slot = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_v[slot]    = 1;
      m_tag[slot]  = ins_tag;
      m_addr[slot] = ins_addr;
      m_sz[slot]   = ins_size;
    end
    return hit;
  endfunction

  task automatic idle();
    ins_valid = 0; chk_valid = 0; chk_clear = 0; inv_all = 0;
    inv_one_valid = 0; snp_valid = 0;
    ins_tag = 0; chk_tag = 0; inv_one_tag = 0; ins_addr = 0; snp_addr = 0;
    ins_size = 0; snp_size = 0; snp_kind = 0;
  endtask

  // One clock: predict, step, sample 1 time unit after the edge, then idle inputs.
  task automatic tick(input string req);
    bit exp_v, exp_h;
    exp_v = chk_valid;
    exp_h = model_step();
    @(posedge clk);
    #1;
    check({req, " resp_valid"}, chk_resp_valid, exp_v);
    if (exp_v) begin
      check({req, " hit"}, chk_hit, exp_h);
      check("R12 zero-entry hit", z_hit, 0);
    end
    check("R12 zero-entry resp_valid", z_resp_valid, exp_v);
    idle();
  endtask

  task automatic do_ins(input int t, input longint unsigned a, input int s);
    ins_valid = 1; ins_tag = 7'(t); ins_addr = a; ins_size = 2'(s);
    tick("R3 insert");
  endtask

  task automatic do_chk(input string req, input int t, input bit clr);
    chk_valid = 1; chk_tag = 7'(t); chk_clear = clr;
    tick(req);
  endtask

  task automatic do_snp(input string req, input int k, input longint unsigned a, input int s);
    snp_valid = 1; snp_kind = 3'(k); snp_addr = a; snp_size = 2'(s);
    tick(req);
  endtask

  task automatic flush();
    inv_all = 1;
    tick("R5 flush");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset resp_valid", chk_resp_valid, 0);
    rst = 0;
    do_chk("R1 empty after reset", 5, 0);

    // R2 basic hit and miss
    do_ins(3, 64'h1000, 3);
    do_chk("R2 hit", 3, 0);
    do_chk("R2 other tag miss", 4, 0);

    // R3 reinsert moves the entry; store on old address leaves it
    do_ins(3, 64'h2000, 3);
    do_snp("R3 old addr store", 0, 64'h1000, 3);
    do_chk("R3 new entry survives", 3, 0);

    // R4 clear semantics
    do_chk("R4 clear on hit", 3, 1);
    do_chk("R4 gone after clear", 3, 0);
    do_ins(8, 64'h2400, 2);
    do_chk("R4 clear on miss", 9, 1);
    do_chk("R4 no-clear keeps", 8, 0);
    do_chk("R4 still present", 8, 0);

    // R5 explicit invalidation
    do_ins(1, 64'h8000, 3);
    do_ins(2, 64'h9000, 3);
    inv_one_valid = 1; inv_one_tag = 7'd2; tick("R5 drop one");
    do_chk("R5 other kept", 1, 0);
    do_chk("R5 dropped", 2, 0);
    flush();
    do_chk("R5 flushed", 1, 0);

    // R6 line-granular store / semaphore
    do_ins(10, 64'h3008, 2);
    do_ins(11, 64'h3030, 1);
    do_ins(12, 64'h3040, 3);
    do_snp("R6 store", 0, 64'h3001, 0);
    do_chk("R6 same line removed", 10, 0);
    do_chk("R6 same line removed 2", 11, 0);
    do_chk("R6 next line kept", 12, 0);
    do_snp("R6 straddling sema", 1, 64'h303E, 2);
    do_chk("R6 straddle removed", 12, 0);
    do_ins(13, 64'h30BE, 2);
    do_snp("R6 store next line", 0, 64'h30C4, 0);
    do_chk("R6 straddling entry removed", 13, 0);

    // R7 page purge
    do_ins(20, 64'h5000, 3);
    do_ins(21, 64'h5FF8, 3);
    do_ins(22, 64'h6000, 3);
    do_snp("R7 purge", 2, 64'h5123, 0);
    do_chk("R7 page start removed", 20, 0);
    do_chk("R7 page end removed", 21, 0);
    do_chk("R7 next page kept", 22, 0);

    // R8 eviction
    do_ins(30, 64'h707E, 2);
    do_ins(31, 64'h7100, 3);
    do_snp("R8 evict", 3, 64'h7080, 3);
    do_chk("R8 touching entry removed", 30, 0);
    do_chk("R8 other line kept", 31, 0);

    // R9 spill and unused kinds
    do_ins(40, 64'hA000, 3);
    do_snp("R9 spill", 4, 64'hA000, 3);
    do_chk("R9 spill no effect", 40, 0);
    do_snp("R9 unused kind", 6, 64'hA000, 3);
    do_chk("R9 unused no effect", 40, 0);

    // R10 same-cycle ordering
    chk_valid = 1; chk_tag = 7'd40; inv_one_valid = 1; inv_one_tag = 7'd40;
    tick("R10 drop beats check");
    do_ins(41, 64'hB000, 3);
    chk_valid = 1; chk_tag = 7'd41; snp_valid = 1; snp_kind = 3'd0; snp_addr = 64'hB004;
    tick("R10 snoop beats check");
    snp_valid = 1; snp_kind = 3'd0; snp_addr = 64'hB010;
    ins_valid = 1; ins_tag = 7'd42; ins_addr = 64'hB000; ins_size = 2'd3;
    tick("R10 insert after snoop");
    do_chk("R10 insert survived", 42, 0);
    chk_valid = 1; chk_tag = 7'd43;
    ins_valid = 1; ins_tag = 7'd43; ins_addr = 64'hC000; ins_size = 2'd3;
    tick("R10 check before insert");
    do_chk("R10 inserted", 43, 0);

    // R11 replacement when full
    flush();
    for (int i = 0; i < N; i++) do_ins(50 + i, 64'h10000 + 64'(i) * 256, 3);
    do_ins(90, 64'h20000, 3);
    do_chk("R11 slot0 replaced", 50, 0);
    do_chk("R11 new entry", 90, 0);
    do_chk("R11 slot1 kept", 51, 0);
    do_ins(91, 64'h20100, 3);
    do_chk("R11 slot1 replaced", 51, 0);
    do_ins(60, 64'h20200, 3);
    do_chk("R11 same tag reuse keeps slot2", 52, 0);

    // mixed random stream against the model
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 40) begin
        ins_valid = 1; ins_tag = 7'($urandom_range(0, 23));
        ins_addr = 64'h40000 + 64'($urandom_range(0, 4095)) * 8 + 64'($urandom_range(0, 7));
        ins_size = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 99) < 50) begin
        chk_valid = 1; chk_tag = 7'($urandom_range(0, 23));
        chk_clear = 1'($urandom_range(0, 1));
      end
      if ($urandom_range(0, 99) < 35) begin
        snp_valid = 1; snp_kind = 3'($urandom_range(0, 7));
        snp_addr = 64'h40000 + 64'($urandom_range(0, 32767));
        snp_size = 2'($urandom_range(0, 3));
      end
      if ($urandom_range(0, 99) < 5) begin
        inv_one_valid = 1; inv_one_tag = 7'($urandom_range(0, 23));
      end
      if ($urandom_range(0, 999) < 5) inv_all = 1;
      tick("R2 R10 mixed");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule